// File: doc/BRIEF.md
# Dynamic Child Allocation Address Unit

This block turns each processor's data addresses into addresses for a banked shared data memory, in a multiprocessor whose tree links are built while programs run. A processor's address holds a child index in its upper bits and an in-block offset in its lower bits. A small per-processor table maps the child index to a physical processor number, and that number also picks the memory block. Entry 0 of every table holds the processor's own number, so index 0 reaches its own data memory. A translated access needs no other logic.

When a processor touches a child index whose entry is still empty, the access stalls and a request goes into that processor's one-slot mailbox. A central controller scans the mailboxes round-robin and serves one request per cycle. It takes the lowest-numbered free processor from a pool and writes that number into the requester's table. It also records, for the new processor, which processor is its parent and which child slot it fills. Upward flag operations (a child setting or clearing its own bit in the parent) go through the same mailboxes. The controller uses the recorded parent data to reach the right bit. If the pool is empty, the controller refuses the request. The requester then keeps the entry empty and raises a sticky status bit, so that its software can fall back to sequential work.

Top module: `cta_unit`

## Requirements
- R1: Address bits [AW-1:OFFW] form the child index n and bits [OFFW-1:0] form the offset r. A translated access drives mem_addr = {mapped number, r}. Entry 0 maps to the processor's own number from reset.
- R2: After reset, entries 1..NCHILD-1 of every table are empty and refused is all zero. child_flags is all zero, flag_ready is all one and stall is all zero. The pool holds processors 1..NPROC-1.
- R3: An access to an empty entry raises stall and keeps mem_valid low. It also posts an allocation request to that processor's mailbox.
- R4: The controller serves at most one mailbox per cycle, scanning from the processor after the last one served (processor 0 first after reset). A stall lasts no more than 2*NPROC+1 cycles.
- R5: An allocation takes the lowest-numbered free processor, removes it from the pool and writes it into the requested entry. The stalled access then completes with that number.
- R6: An allocated processor c records its parent p and its child index j. A flag operation from c then writes its value into child_flags[p*NCHILD+j].
- R7: With an empty pool, a request is refused: the entry stays empty and refused[i] is set and stays set. After that, accesses by processor i to empty entries neither stall nor translate.
- R8: A flag operation from a processor that has no parent is discarded, and child_flags does not change.
- R9: flag_ready[i] is high only when processor i's mailbox is empty and it is not stalled. A flag operation is accepted only while flag_ready is high.
- R10: An access to a filled entry translates in the same cycle, whatever requests the controller is serving.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | NPROC | Per-processor access request |
| acc_addr | input | NPROC*AW | Per-processor address {n, r} |
| flag_valid | input | NPROC | Per-processor upward flag operation |
| flag_val | input | NPROC | Value to write into the parent's flag bit |
| flag_ready | output | NPROC | Mailbox can accept a flag operation |
| mem_valid | output | NPROC | Access translated this cycle |
| mem_addr | output | NPROC*MW | Translated address {processor number, r} |
| stall | output | NPROC | Access waiting on allocation |
| refused | output | NPROC | Sticky status: an allocation was refused |
| child_flags | output | NPROC*NCHILD | Flag bit of child j in parent p at p*NCHILD+j |

## Verification
The hardest situation to reach is several mailboxes pending at once while the pool is nearly empty. Here the round-robin order decides which processor gets the last free number and which ones are refused. The stimulus first builds a known tree and a known last-served pointer through directed allocations and flag operations. It then fires three allocation requests in one cycle with one processor left in the pool, and checks the serving order cycle by cycle. Random accesses afterwards check translation, refusal behaviour and the stall bound against a model table kept in the bench.

// File: rtl/cta_pkg.sv
package cta_pkg;

    localparam int CTA_NPROC_D  = 4;
    localparam int CTA_NCHILD_D = 4;
    localparam int CTA_OFFW_D   = 6;

    typedef enum logic {
        MB_ALLOC = 1'b0,
        MB_FLAG  = 1'b1
    } mb_kind_e;

    typedef struct packed {
        logic     pend;
        mb_kind_e kind;
        logic     val;
    } mb_head_t;

    // next index in a ring of size m
    function automatic int ring_step(input int base, input int k, input int m);
        return (base + k) % m;
    endfunction

endpackage

// File: rtl/cta_mailbox.sv
module cta_mailbox
    import cta_pkg::*;
#(
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          need_alloc,
    input  logic [IW-1:0] need_idx,
    input  logic          flag_valid,
    input  logic          flag_val,
    input  logic          take,
    output logic          pend,
    output logic          is_flag,
    output logic [IW-1:0] idx,
    output logic          val,
    output logic          flag_ready
);

    mb_head_t      head_q;
    logic [IW-1:0] idx_q;

    assign pend       = head_q.pend;
    assign is_flag    = (head_q.kind == MB_FLAG);
    assign val        = head_q.val;
    assign idx        = idx_q;
    assign flag_ready = !head_q.pend && !need_alloc;

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '{pend: 1'b0, kind: MB_ALLOC, val: 1'b0};
            idx_q  <= '0;
        end else if (take) begin
            head_q.pend <= 1'b0;
        end else if (!head_q.pend) begin
            if (need_alloc) begin
                head_q <= '{pend: 1'b1, kind: MB_ALLOC, val: 1'b0};
                idx_q  <= need_idx;
            end else if (flag_valid) begin
                head_q <= '{pend: 1'b1, kind: MB_FLAG, val: flag_val};
            end
        end
    end

endmodule

// File: rtl/cta_map_table.sv
module cta_map_table #(
    parameter int NCHILD = 4,
    parameter int NPROC  = 4,
    parameter int OFFW   = 6,
    parameter int SELF   = 0,
    localparam int IW    = $clog2(NCHILD),
    localparam int PW    = $clog2(NPROC),
    localparam int AW    = IW + OFFW,
    localparam int MW    = PW + OFFW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic          refused,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [PW-1:0] wr_num,
    output logic          mem_valid,
    output logic [MW-1:0] mem_addr,
    output logic          stall,
    output logic [IW-1:0] need_idx
);

    logic [NCHILD-1:0] ent_valid_q;
    logic [PW-1:0]     ent_num_q [NCHILD];

    logic [IW-1:0]   n_sel;
    logic [OFFW-1:0] r_off;
    logic            hit;

    assign n_sel    = acc_addr[AW-1:OFFW];
    assign r_off    = acc_addr[OFFW-1:0];
    assign hit      = ent_valid_q[n_sel];
    assign need_idx = n_sel;

    always_comb begin
        mem_valid = acc_valid && hit;
        mem_addr  = {ent_num_q[n_sel], r_off};
        stall     = acc_valid && !hit && !refused;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int e = 0; e < NCHILD; e++) begin
                ent_valid_q[e] <= (e == 0);
                ent_num_q[e]   <= (e == 0) ? PW'(SELF) : '0;
            end
        end else if (wr_en) begin
            ent_valid_q[wr_idx] <= 1'b1;
            ent_num_q[wr_idx]   <= wr_num;
        end
    end

endmodule

// File: rtl/cta_free_pool.sv
module cta_free_pool #(
    parameter int NPROC = 4,
    localparam int PW   = $clog2(NPROC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    output logic          any_free,
    output logic [PW-1:0] low_num
);

    logic [NPROC-1:0] free_q;

    assign any_free = |free_q;

    always_comb begin
        low_num = '0;
        for (int i = NPROC - 1; i >= 0; i--) begin
            if (free_q[i]) low_num = PW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            free_q    <= '1;
            free_q[0] <= 1'b0;
        end else if (take && any_free) begin
            free_q[low_num] <= 1'b0;
        end
    end

endmodule

// File: rtl/cta_controller.sv
module cta_controller
    import cta_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int NCHILD = 4,
    localparam int PW    = $clog2(NPROC),
    localparam int IW    = $clog2(NCHILD)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPROC-1:0]        mb_pend,
    input  logic [NPROC-1:0]        mb_is_flag,
    input  logic [NPROC*IW-1:0]     mb_idx,
    input  logic [NPROC-1:0]        mb_val,
    input  logic                    pool_any,
    input  logic [PW-1:0]           pool_num,
    output logic                    pool_take,
    output logic [NPROC-1:0]        take,
    output logic [NPROC-1:0]        wr_en,
    output logic [IW-1:0]           wr_idx,
    output logic [PW-1:0]           wr_num,
    output logic [NPROC-1:0]        refused,
    output logic [NPROC*NCHILD-1:0] child_flags
);

    logic [PW-1:0]            last_q;
    logic [NPROC-1:0]         refused_q;
    logic [NPROC*NCHILD-1:0]  flags_q;
    logic [NPROC-1:0]         has_par_q;
    logic [PW-1:0]            par_num_q [NPROC];
    logic [IW-1:0]            par_idx_q [NPROC];

    logic          found;
    logic [PW-1:0] sel;
    logic [IW-1:0] sel_idx;
    logic          sel_flag;
    logic          do_alloc;
    int            cand;

    always_comb begin
        found = 1'b0;
        sel   = '0;
        cand  = 0;
        for (int k = 1; k <= NPROC; k++) begin
            cand = ring_step(int'(last_q), k, NPROC);
            if (!found && mb_pend[cand]) begin
                found = 1'b1;
                sel   = PW'(cand);
            end
        end
    end

    assign sel_idx  = mb_idx[sel*IW +: IW];
    assign sel_flag = mb_is_flag[sel];
    assign do_alloc = found && !sel_flag && pool_any;

    always_comb begin
        take   = '0;
        wr_en  = '0;
        if (found)    take[sel]  = 1'b1;
        if (do_alloc) wr_en[sel] = 1'b1;
    end

    assign pool_take   = do_alloc;
    assign wr_idx      = sel_idx;
    assign wr_num      = pool_num;
    assign refused     = refused_q;
    assign child_flags = flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q    <= PW'(NPROC - 1);
            refused_q <= '0;
            flags_q   <= '0;
            has_par_q <= '0;
            for (int i = 0; i < NPROC; i++) begin
                par_num_q[i] <= '0;
                par_idx_q[i] <= '0;
            end
        end else if (found) begin
            last_q <= sel;
            if (!sel_flag) begin
                if (pool_any) begin
                    has_par_q[pool_num] <= 1'b1;
                    par_num_q[pool_num] <= sel;
                    par_idx_q[pool_num] <= sel_idx;
                end else begin
                    refused_q[sel] <= 1'b1;
                end
            end else if (has_par_q[sel]) begin
                flags_q[int'(par_num_q[sel]) * NCHILD + int'(par_idx_q[sel])] <= mb_val[sel];
            end
        end
    end

endmodule

// File: rtl/cta_unit.sv
module cta_unit #(
    parameter int NPROC  = cta_pkg::CTA_NPROC_D,
    parameter int NCHILD = cta_pkg::CTA_NCHILD_D,
    parameter int OFFW   = cta_pkg::CTA_OFFW_D,
    localparam int PW    = $clog2(NPROC),
    localparam int IW    = $clog2(NCHILD),
    localparam int AW    = IW + OFFW,
    localparam int MW    = PW + OFFW
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NPROC-1:0]        acc_valid,
    input  logic [NPROC*AW-1:0]     acc_addr,
    input  logic [NPROC-1:0]        flag_valid,
    input  logic [NPROC-1:0]        flag_val,
    output logic [NPROC-1:0]        flag_ready,
    output logic [NPROC-1:0]        mem_valid,
    output logic [NPROC*MW-1:0]     mem_addr,
    output logic [NPROC-1:0]        stall,
    output logic [NPROC-1:0]        refused,
    output logic [NPROC*NCHILD-1:0] child_flags
);

    logic [NPROC-1:0]    mb_pend;
    logic [NPROC-1:0]    mb_is_flag;
    logic [NPROC*IW-1:0] mb_idx;
    logic [NPROC-1:0]    mb_val;
    logic [NPROC-1:0]    mb_take;
    logic [NPROC-1:0]    tbl_wr_en;
    logic [IW-1:0]       tbl_wr_idx;
    logic [PW-1:0]       tbl_wr_num;
    logic [NPROC*IW-1:0] need_idx;
    logic                pool_any;
    logic [PW-1:0]       pool_num;
    logic                pool_take;

    for (genvar g = 0; g < NPROC; g++) begin : g_proc
        cta_map_table #(
            .NCHILD (NCHILD),
            .NPROC  (NPROC),
            .OFFW   (OFFW),
            .SELF   (g)
        ) u_tbl (
            .clk       (clk),
            .rst       (rst),
            .acc_valid (acc_valid[g]),
            .acc_addr  (acc_addr[g*AW +: AW]),
            .refused   (refused[g]),
            .wr_en     (tbl_wr_en[g]),
            .wr_idx    (tbl_wr_idx),
            .wr_num    (tbl_wr_num),
            .mem_valid (mem_valid[g]),
            .mem_addr  (mem_addr[g*MW +: MW]),
            .stall     (stall[g]),
            .need_idx  (need_idx[g*IW +: IW])
        );

        cta_mailbox #(
            .IW (IW)
        ) u_mb (
            .clk        (clk),
            .rst        (rst),
            .need_alloc (stall[g]),
            .need_idx   (need_idx[g*IW +: IW]),
            .flag_valid (flag_valid[g]),
            .flag_val   (flag_val[g]),
            .take       (mb_take[g]),
            .pend       (mb_pend[g]),
            .is_flag    (mb_is_flag[g]),
            .idx        (mb_idx[g*IW +: IW]),
            .val        (mb_val[g]),
            .flag_ready (flag_ready[g])
        );
    end

    cta_free_pool #(
        .NPROC (NPROC)
    ) u_pool (
        .clk      (clk),
        .rst      (rst),
        .take     (pool_take),
        .any_free (pool_any),
        .low_num  (pool_num)
    );

    cta_controller #(
        .NPROC  (NPROC),
        .NCHILD (NCHILD)
    ) u_ctl (
        .clk         (clk),
        .rst         (rst),
        .mb_pend     (mb_pend),
        .mb_is_flag  (mb_is_flag),
        .mb_idx      (mb_idx),
        .mb_val      (mb_val),
        .pool_any    (pool_any),
        .pool_num    (pool_num),
        .pool_take   (pool_take),
        .take        (mb_take),
        .wr_en       (tbl_wr_en),
        .wr_idx      (tbl_wr_idx),
        .wr_num      (tbl_wr_num),
        .refused     (refused),
        .child_flags (child_flags)
    );

endmodule

// File: rtl/cta_unit_checker.sv
module cta_unit_checker #(
    parameter int NPROC  = 4,
    parameter int NCHILD = 4,
    parameter int OFFW   = 6,
    localparam int PW    = $clog2(NPROC),
    localparam int IW    = $clog2(NCHILD),
    localparam int AW    = IW + OFFW,
    localparam int MW    = PW + OFFW,
    localparam int LIM   = 2 * NPROC + 1,
    localparam int CW    = $clog2(LIM + 2) + 1
) (
    input logic                clk,
    input logic                rst,
    input logic [NPROC-1:0]    acc_valid,
    input logic [NPROC*AW-1:0] acc_addr,
    input logic [NPROC-1:0]    mem_valid,
    input logic [NPROC*MW-1:0] mem_addr,
    input logic [NPROC-1:0]    stall,
    input logic [NPROC-1:0]    refused,
    input logic [NPROC-1:0]    flag_ready,
    input logic [NPROC-1:0]    tbl_wr_en
);

    // R4: one table write per cycle at most
    p_single_write_r4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tbl_wr_en));

    for (genvar i = 0; i < NPROC; i++) begin : g_chk
        logic [CW-1:0] wait_q;

        always_ff @(posedge clk) begin
            if (rst || !stall[i]) wait_q <= '0;
            else if (wait_q <= CW'(LIM)) wait_q <= wait_q + 1'b1;
        end

        p_stall_no_xlate_r3: assert property (@(posedge clk) disable iff (rst)
            stall[i] |-> !mem_valid[i]);

        p_own_entry_r1: assert property (@(posedge clk) disable iff (rst)
            (acc_valid[i] && acc_addr[i*AW+OFFW +: IW] == '0)
            |-> (mem_valid[i] && mem_addr[i*MW+OFFW +: PW] == PW'(i)));

        p_offset_pass_r1: assert property (@(posedge clk) disable iff (rst)
            mem_valid[i] |-> mem_addr[i*MW +: OFFW] == acc_addr[i*AW +: OFFW]);

        p_refused_sticky_r7: assert property (@(posedge clk) disable iff (rst)
            refused[i] |=> refused[i]);

        p_flag_ready_r9: assert property (@(posedge clk) disable iff (rst)
            flag_ready[i] |-> !stall[i]);

        p_stall_bound_r4: assert property (@(posedge clk) disable iff (rst)
            wait_q <= CW'(LIM));
    end

endmodule

bind cta_unit cta_unit_checker #(
    .NPROC  (NPROC),
    .NCHILD (NCHILD),
    .OFFW   (OFFW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_addr   (acc_addr),
    .mem_valid  (mem_valid),
    .mem_addr   (mem_addr),
    .stall      (stall),
    .refused    (refused),
    .flag_ready (flag_ready),
    .tbl_wr_en  (tbl_wr_en)
);

// File: tb/cta_unit_bench.sv
`timescale 1ns/1ps
module cta_unit_bench;

    localparam int NPROC  = 4;
    localparam int NCHILD = 4;
    localparam int OFFW   = 6;
    localparam int PW     = $clog2(NPROC);
    localparam int IW     = $clog2(NCHILD);
    localparam int AW     = IW + OFFW;
    localparam int MW     = PW + OFFW;
    localparam int LIM    = 2 * NPROC + 1;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [NPROC-1:0]        acc_valid = '0;
    logic [NPROC*AW-1:0]     acc_addr = '0;
    logic [NPROC-1:0]        flag_valid = '0;
    logic [NPROC-1:0]        flag_val = '0;
    logic [NPROC-1:0]        flag_ready;
    logic [NPROC-1:0]        mem_valid;
    logic [NPROC*MW-1:0]     mem_addr;
    logic [NPROC-1:0]        stall;
    logic [NPROC-1:0]        refused;
    logic [NPROC*NCHILD-1:0] child_flags;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 0;

    // bench model: mapping valid/number and refusal state
    bit  m_ok  [NPROC][NCHILD];
    int  m_num [NPROC][NCHILD];
    bit  m_ref [NPROC];

    cta_unit #(.NPROC(NPROC), .NCHILD(NCHILD), .OFFW(OFFW)) u_cta_unit (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .flag_valid(flag_valid), .flag_val(flag_val), .flag_ready(flag_ready),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .stall(stall),
        .refused(refused), .child_flags(child_flags)
    );

    always #4 clk = ~clk;

    function automatic int xaddr(input int num, input int r);
        return num * (1 << OFFW) + r;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input int p, input int n, input int r);
        @(negedge clk);
        acc_valid = '0;
        acc_valid[p] = 1'b1;
        acc_addr[p*AW +: AW] = AW'(n * (1 << OFFW) + r);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        acc_valid = '0;
    endtask

    task automatic wait_stall(input int p, output int cyc);
        cyc = 0;
        while (stall[p] && cyc < 40) begin
            @(negedge clk);
            #1;
            cyc++;
        end
    endtask

    task automatic flag_op(input int p, input bit v);
        @(negedge clk);
        check(flag_ready[p], "R9 ready before flag", int'(flag_ready[p]), 1);
        flag_valid[p] = 1'b1;
        flag_val[p]   = v;
        @(negedge clk);
        flag_valid = '0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int cyc;
        void'($urandom(32'h1f3a));
        for (int p = 0; p < NPROC; p++) begin
            m_ref[p] = 0;
            for (int n = 0; n < NCHILD; n++) begin
                m_ok[p][n]  = (n == 0);
                m_num[p][n] = (n == 0) ? p : 0;
            end
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R2 reset state
        check(refused == '0, "R2 refused", int'(refused), 0);
        check(child_flags == '0, "R2 flags", int'(child_flags), 0);
        check(stall == '0, "R2 stall", int'(stall), 0);
        check(flag_ready == '1, "R2 flag_ready", int'(flag_ready), 15);

        // R1 own entry for each processor
        for (int p = 0; p < NPROC; p++) begin
            drive(p, 0, 5 + p);
            check(mem_valid[p] && int'(mem_addr[p*MW +: MW]) == xaddr(p, 5 + p),
                  "R1 own entry", int'(mem_addr[p*MW +: MW]), xaddr(p, 5 + p));
        end
        idle();

        // R3 stall on empty entry, R9 ready low while stalled
        drive(0, 1, 7);
        check(stall[0] && !mem_valid[0], "R3 stall", int'(stall[0]), 1);
        check(!flag_ready[0], "R9 ready during stall", int'(flag_ready[0]), 0);
        wait_stall(0, cyc);
        check(cyc <= LIM, "R4 stall bound", cyc, LIM);
        // R5 lowest free processor 1
        check(mem_valid[0] && int'(mem_addr[0 +: MW]) == xaddr(1, 7),
              "R5 alloc 1", int'(mem_addr[0 +: MW]), xaddr(1, 7));
        m_ok[0][1] = 1; m_num[0][1] = 1;
        drive(0, 2, 9);
        wait_stall(0, cyc);
        check(mem_valid[0] && int'(mem_addr[0 +: MW]) == xaddr(2, 9),
              "R5 alloc 2", int'(mem_addr[0 +: MW]), xaddr(2, 9));
        m_ok[0][2] = 1; m_num[0][2] = 2;
        idle();

        // R6 flags through parent record (parent 0, child 1 -> bit 1, child 2 -> bit 2)
        flag_op(1, 1'b1);
        check(child_flags == 16'h0002, "R6 child1 set", int'(child_flags), 2);
        flag_op(2, 1'b1);
        check(child_flags == 16'h0006, "R6 child2 set", int'(child_flags), 6);
        flag_op(1, 1'b0);
        check(child_flags == 16'h0004, "R6 child1 clear", int'(child_flags), 4);
        // R8 processor 3 has no parent
        flag_op(3, 1'b1);
        check(child_flags == 16'h0004, "R8 orphan flag", int'(child_flags), 4);

        // R4/R7: three requests at once, one free processor left, scan starts at 0
        @(negedge clk);
        acc_valid = 4'b0111;
        acc_addr[0*AW +: AW] = AW'(3 * (1 << OFFW) + 1);
        acc_addr[1*AW +: AW] = AW'(1 * (1 << OFFW) + 2);
        acc_addr[2*AW +: AW] = AW'(3 * (1 << OFFW) + 3);
        @(negedge clk);
        @(negedge clk);
        #1;
        check(mem_valid[0] && int'(mem_addr[0 +: MW]) == xaddr(3, 1),
              "R4 first served gets 3", int'(mem_addr[0 +: MW]), xaddr(3, 1));
        check(stall[1] && stall[2], "R4 others waiting", int'(stall), 6);
        @(negedge clk);
        #1;
        check(refused == 4'b0010 && stall[2], "R4 order refuse 1 first", int'(refused), 2);
        repeat (3) @(negedge clk);
        #1;
        check(refused == 4'b0110, "R7 refused", int'(refused), 6);
        check(!stall[1] && !stall[2] && !mem_valid[1] && !mem_valid[2],
              "R7 no stall after refusal", int'({stall[2:1], mem_valid[2:1]}), 0);
        m_ok[0][3] = 1; m_num[0][3] = 3;
        m_ref[1] = 1; m_ref[2] = 1;
        idle();

        // random accesses against the model (R1, R7, R10)
        for (int it = 0; it < 300; it++) begin
            int p, n, r;
            p = $urandom_range(NPROC - 1);
            n = $urandom_range(NCHILD - 1);
            r = $urandom_range((1 << OFFW) - 1);
            drive(p, n, r);
            if (m_ok[p][n]) begin
                check(mem_valid[p] && int'(mem_addr[p*MW +: MW]) == xaddr(m_num[p][n], r),
                      "R10 random translate", int'(mem_addr[p*MW +: MW]), xaddr(m_num[p][n], r));
            end else if (m_ref[p]) begin
                check(!stall[p] && !mem_valid[p], "R7 random refused",
                      int'({stall[p], mem_valid[p]}), 0);
            end else begin
                check(stall[p], "R3 random stall", int'(stall[p]), 1);
                wait_stall(p, cyc);
                check(cyc <= LIM && refused[p] && !mem_valid[p], "R7 random refusal",
                      int'(refused[p]), 1);
                m_ref[p] = 1;
            end
            idle();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule